// File: doc/BRIEF.md
# Iterative Shift and Rotate Unit with Carry

This block shifts or rotates an 8-bit or 16-bit operand by a chosen number of bit positions and produces the new carry, overflow, sign, zero and parity flags. Seven operations are supported: logical left shift (which is also the arithmetic left shift), logical right shift, arithmetic right shift, plain left and right rotates, and left and right rotates through the carry flag. The count is either the constant 1 or the value of an 8-bit count input, so a single request can move the operand by 0 to 255 positions.

The unit handles one bit position per clock cycle. A request is taken on a `start` pulse while the unit is idle. `busy` stays high while the unit steps through the count. `done` then pulses for one cycle, and the result and flag outputs hold their values from that point until the next request is accepted. The caller passes in the current flag values. Any flag that an operation does not change comes back unchanged.

Top module: `shift_rotate_unit`

## Requirements
- R1: The `op` encodings are 0 = left shift, 1 = logical right shift, 2 = arithmetic right shift, 3 = rotate left, 4 = rotate right, 5 = rotate left through carry, 6 = rotate right through carry, and 7 = left shift (alias of 0). A left shift fills the vacated low bits with zeros, and `cf_out` takes the last bit shifted out of the MSB.
- R2: A logical right shift fills the vacated high bits with zeros. An arithmetic right shift fills them with the original sign bit. In both cases `cf_out` takes the last bit shifted out of bit 0. For example, 091Ah arithmetic-shifted by 2 gives 0246h with carry 1, and 800Fh arithmetic-shifted by 4 gives F800h with carry 1.
- R3: A plain rotate puts each bit that leaves one end back in at the other end, and `cf_out` takes the last bit moved.
- R4: A rotate through carry treats the carry as one extra bit position. On a left rotate, the prior carry enters bit 0 and the outgoing MSB enters the carry. A right rotate does the mirror of this. For example, 1234h rotated right through carry by 4 with carry 0 gives 8123h with carry 0.
- R5: When `use_reg` is 0 the count is 1. When `use_reg` is 1 the count is `cnt_reg` (0 to 255). Call the edge that samples an accepted `start` edge 0. For a count of N, `done` is high for exactly the one cycle that follows rising edge N+1, and `busy` is high from edge 0 until that edge.
- R6: A count of 0 returns the operand unchanged and returns all five flags equal to their inputs.
- R7: For a count of exactly 1, `of_out` is set as follows:
  - For left shifts and left rotates, `of_out` is the result MSB XOR `cf_out`.
  - For the logical right shift, `of_out` is the original MSB.
  - For the arithmetic right shift, `of_out` is 0.
  - For both right rotates, `of_out` is the XOR of the two top bits of the result.
- R8: For a count of 2 or more, `of_out` equals `of_in`.
- R9: For a nonzero count, the shift operations (op 0, 1, 2, 7) update the sign, zero and parity flags from the result:
  - `sf_out` is the result MSB.
  - `zf_out` is 1 when the result is zero.
  - `pf_out` is 1 when the low byte of the result has an even number of ones.
  The rotate operations return `sf_in`, `zf_in` and `pf_in` unchanged.
- R10: With `wide` = 0, only `operand[7:0]` takes part, the MSB is bit 7, the upper byte of the operand is ignored, and `result[15:8]` is 0.
- R11: A `start` pulse while `busy` is high is ignored. The request in progress completes with its own operand and operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken while idle |
| op | input | 3 | Operation select (encoding in R1) |
| wide | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| use_reg | input | 1 | 1 = count from cnt_reg, 0 = count of 1 |
| cnt_reg | input | CNT_W (8) | Count value |
| operand | input | 16 | Data to shift or rotate |
| cf_in | input | 1 | Incoming carry flag |
| of_in | input | 1 | Incoming overflow flag |
| sf_in | input | 1 | Incoming sign flag |
| zf_in | input | 1 | Incoming zero flag |
| pf_in | input | 1 | Incoming parity flag |
| result | output | 16 | Shifted or rotated value |
| cf_out | output | 1 | New carry flag |
| of_out | output | 1 | New overflow flag |
| sf_out | output | 1 | New sign flag |
| zf_out | output | 1 | New zero flag |
| pf_out | output | 1 | New parity flag |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: the completion pulse of one request and the acceptance of the next request. This happens because `busy` is already low while `done` is high. The bench provokes this on every request. It reads the outputs at the falling edge where `done` is first seen and, at that same edge, drives the next `start`. It then judges both the latched outputs of the finished request and the exact latency of the new one. The bench also drives a `start` carrying a different operand into the first busy cycle of selected requests, and requires the finished result to match the original request only.

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic             wide,
  input  logic             use_reg,
  input  logic [CNT_W-1:0] cnt_reg,
  input  logic [15:0]      operand,
  input  logic             cf_in,
  input  logic             of_in,
  input  logic             sf_in,
  input  logic             zf_in,
  input  logic             pf_in,
  output logic [15:0]      result,
  output logic             cf_out,
  output logic             of_out,
  output logic             sf_out,
  output logic             zf_out,
  output logic             pf_out,
  output logic             busy,
  output logic             done
);
  localparam logic [2:0] OP_SHL = 3'd0, OP_SHR = 3'd1, OP_SAR = 3'd2, OP_ROL = 3'd3,
                         OP_ROR = 3'd4, OP_RCL = 3'd5, OP_RCR = 3'd6, OP_SAL = 3'd7;

  logic [2:0]       op_q;
  logic             wide_q, one_q, zero_q, msb0_q;
  logic [CNT_W-1:0] rem_q;

  logic        is_left, is_rot, msb, msb2, lin, rin, bit_out;
  logic [15:0] nxt;
  logic [CNT_W-1:0] eff_cnt;

  assign eff_cnt = use_reg ? cnt_reg : CNT_W'(1);
  assign is_left = (op_q == OP_SHL) || (op_q == OP_SAL) || (op_q == OP_ROL) || (op_q == OP_RCL);
  assign is_rot  = (op_q == OP_ROL) || (op_q == OP_ROR) || (op_q == OP_RCL) || (op_q == OP_RCR);
  assign msb     = wide_q ? result[15] : result[7];
  assign msb2    = wide_q ? result[14] : result[6];
  assign lin     = (op_q == OP_ROL) ? msb : (op_q == OP_RCL) ? cf_out : 1'b0;
  assign rin     = (op_q == OP_SAR) ? msb : (op_q == OP_ROR) ? result[0] :
                   (op_q == OP_RCR) ? cf_out : 1'b0;
  assign bit_out = is_left ? msb : result[0];

  always_comb begin
    if (is_left) begin
      nxt = {result[14:0], lin};
    end else begin
      nxt = {1'b0, result[15:1]};
      if (wide_q) nxt[15] = rin;
      else        nxt[7]  = rin;
    end
    if (!wide_q) nxt[15:8] = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0; cf_out <= 1'b0; of_out <= 1'b0; sf_out <= 1'b0;
      zf_out <= 1'b0; pf_out <= 1'b0; busy <= 1'b0; done <= 1'b0;
      op_q <= '0; wide_q <= 1'b0; one_q <= 1'b0; zero_q <= 1'b0;
      msb0_q <= 1'b0; rem_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          result <= wide ? operand : {8'h00, operand[7:0]};
          cf_out <= cf_in; of_out <= of_in; sf_out <= sf_in;
          zf_out <= zf_in; pf_out <= pf_in;
          op_q   <= op;
          wide_q <= wide;
          rem_q  <= eff_cnt;
          one_q  <= (eff_cnt == CNT_W'(1));
          zero_q <= (eff_cnt == '0);
          msb0_q <= wide ? operand[15] : operand[7];
          busy   <= 1'b1;
        end
      end else if (rem_q != '0) begin
        result <= nxt;
        cf_out <= bit_out;
        rem_q  <= rem_q - CNT_W'(1);
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
        if (!zero_q && !is_rot) begin
          sf_out <= msb;
          zf_out <= (result == 16'h0000);
          pf_out <= ~^result[7:0];
        end
        if (one_q) begin
          if (is_left)              of_out <= msb ^ cf_out;
          else if (op_q == OP_SHR)  of_out <= msb0_q;
          else if (op_q == OP_SAR)  of_out <= 1'b0;
          else                      of_out <= msb ^ msb2;
        end
      end
    end
  end

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_one_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !use_reg) |=> ##2 done);
  p_zero_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && use_reg && cnt_reg == '0) |=> ##1 done);
  p_sar_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && one_q && op_q == OP_SAR) |-> !of_out);
  p_rot_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_rot) |=> ($stable(sf_out) && $stable(zf_out) && $stable(pf_out)));
  p_byte_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wide_q) |-> (result[15:8] == 8'h00));
  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(op_q));
endmodule

// File: tb/shift_rotate_unit_tb.sv
`timescale 1ns/1ps
module shift_rotate_unit_tb;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0]  op = '0;
  logic        wide = 1'b0, use_reg = 1'b0;
  logic [7:0]  cnt_reg = '0;
  logic [15:0] operand = '0;
  logic        cf_in = 0, of_in = 0, sf_in = 0, zf_in = 0, pf_in = 0;
  logic [15:0] result;
  logic        cf_out, of_out, sf_out, zf_out, pf_out, busy, done;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  shift_rotate_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide), .use_reg(use_reg),
    .cnt_reg(cnt_reg), .operand(operand), .cf_in(cf_in), .of_in(of_in), .sf_in(sf_in),
    .zf_in(zf_in), .pf_in(pf_in), .result(result), .cf_out(cf_out), .of_out(of_out),
    .sf_out(sf_out), .zf_out(zf_out), .pf_out(pf_out), .busy(busy), .done(done));

  // packs {result, cf, of, sf, zf, pf}
  function automatic logic [20:0] model(input logic [2:0] o, input logic w16,
      input logic [15:0] d0, input logic c0, input logic v0, input logic s0,
      input logic z0, input logic p0, input int cnt);
    int          w = w16 ? 16 : 8;
    logic [15:0] m = w16 ? 16'hFFFF : 16'h00FF;
    logic [15:0] d = d0 & m;
    logic        c = c0, v = v0, s = s0, z = z0, p = p0, t;
    logic        top0 = d[w-1];
    for (int i = 0; i < cnt; i++) begin
      case (o)
        3'd1: begin t = d[0]; d = d >> 1; end
        3'd2: begin t = d[0]; d = (d >> 1) | (16'(top0) << (w-1)); end
        3'd3: begin t = d[w-1]; d = ((d << 1) | 16'(t)) & m; end
        3'd4: begin t = d[0]; d = (d >> 1) | (16'(t) << (w-1)); end
        3'd5: begin t = d[w-1]; d = ((d << 1) | 16'(c)) & m; end
        3'd6: begin t = d[0]; d = (d >> 1) | (16'(c) << (w-1)); end
        default: begin t = d[w-1]; d = (d << 1) & m; end
      endcase
      c = t;
    end
    if (cnt > 0 && !(o inside {3'd3, 3'd4, 3'd5, 3'd6})) begin
      s = d[w-1]; z = (d == 0); p = ~^d[7:0];
    end
    if (cnt == 1) begin
      case (o)
        3'd1: v = top0;
        3'd2: v = 1'b0;
        3'd4, 3'd6: v = d[w-1] ^ d[w-2];
        default: v = d[w-1] ^ c;
      endcase
    end
    return {d, c, v, s, z, p};
  endfunction

  task automatic run(input string req, input logic [2:0] o, input logic w16, input logic ur,
      input logic [7:0] cr, input logic [15:0] d, input logic [4:0] fl, input logic inject);
    int n = ur ? int'(cr) : 1;
    logic [20:0] exp_v = model(o, w16, d, fl[4], fl[3], fl[2], fl[1], fl[0], n);
    int k = 0;
    op = o; wide = w16; use_reg = ur; cnt_reg = cr; operand = d;
    {cf_in, of_in, sf_in, zf_in, pf_in} = fl;
    start = 1'b1;
    do begin
      @(negedge clk); k++;
      if (k == 1) begin
        if (inject) begin operand = ~d; op = o + 3'd1; cf_in = ~fl[4]; end
        else start = 1'b0;
      end
      if (k == 2) start = 1'b0;
    end while (!done && k < 300);
    n_chk++;
    if (k != n + 2) begin
      n_bad++;
      $display("FAIL %s R5 latency op=%0d cnt=%0d actual=%0d expected=%0d", req, o, n, k, n + 2);
    end
    n_chk++;
    if ({result, cf_out, of_out, sf_out, zf_out, pf_out} !== exp_v) begin
      n_bad++;
      $display("FAIL %s op=%0d w=%0d cnt=%0d d=%h actual=%h expected=%h", req, o, w16, n, d,
               {result, cf_out, of_out, sf_out, zf_out, pf_out}, exp_v);
    end
  endtask

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd1, 3'd2: return "R2";
      3'd3, 3'd4: return "R3";
      3'd5, 3'd6: return "R4";
      default:    return "R1";
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if ({result, busy, done, cf_out} !== 19'h0) begin
      n_bad++;
      $display("FAIL reset R5 actual=%h expected=0", {result, busy, done, cf_out});
    end
    rst_n = 1'b1;
    @(negedge clk);
    run("R2 sar", 3'd2, 1, 1, 8'd2, 16'h091A, 5'b00000, 0);
    run("R2 sar", 3'd2, 1, 1, 8'd4, 16'h800F, 5'b10000, 0);
    run("R4 rcr", 3'd6, 1, 1, 8'd4, 16'h1234, 5'b00000, 0);
    run("R1 shl", 3'd0, 1, 0, 8'd0, 16'h1234, 5'b00000, 0);
    run("R1 sal7", 3'd7, 1, 1, 8'd3, 16'hF001, 5'b00000, 0);
    run("R2 shr", 3'd1, 1, 1, 8'd2, 16'h1234, 5'b10000, 0);
    run("R3 rol", 3'd3, 1, 0, 8'd0, 16'h1234, 5'b00000, 0);
    run("R3 ror", 3'd4, 1, 1, 8'd4, 16'h1234, 5'b00000, 0);
    run("R4 rcl", 3'd5, 1, 0, 8'd0, 16'h8000, 5'b10000, 0);
    run("R6 zero count", 3'd0, 1, 1, 8'd0, 16'hBEEF, 5'b10101, 0);
    run("R6 zero count", 3'd5, 0, 1, 8'd0, 16'h12A5, 5'b01010, 0);
    run("R7 shr one", 3'd1, 1, 0, 8'd0, 16'h8001, 5'b00000, 0);
    run("R7 sar one", 3'd2, 0, 0, 8'd0, 16'h0081, 5'b01000, 0);
    run("R7 ror one", 3'd4, 0, 0, 8'd0, 16'h0001, 5'b00000, 0);
    run("R8 of kept", 3'd0, 1, 1, 8'd2, 16'h4000, 5'b01000, 0);
    run("R9 zero flag", 3'd1, 0, 1, 8'd8, 16'h00FF, 5'b00000, 0);
    run("R9 rot keeps flags", 3'd3, 1, 1, 8'd5, 16'h0000, 5'b00111, 0);
    run("R10 byte", 3'd0, 0, 1, 8'd1, 16'hFF81, 5'b00000, 0);
    run("R10 byte sar", 3'd2, 0, 1, 8'd3, 16'h5590, 5'b00000, 0);
    run("R5 count 255", 3'd6, 1, 1, 8'd255, 16'hA5C3, 5'b10000, 0);
    run("R5 count 255", 3'd2, 0, 1, 8'd255, 16'h0080, 5'b00000, 0);
    run("R11 start busy", 3'd3, 1, 1, 8'd6, 16'h8421, 5'b00000, 1);
    run("R11 start busy", 3'd0, 0, 1, 8'd0, 16'h0033, 5'b00000, 1);
    void'($urandom(32'd4711));
    for (int i = 0; i < 200; i++) begin
      logic [2:0]  ro = 3'($urandom);
      logic        rw = 1'($urandom);
      logic        ru = 1'($urandom);
      logic [7:0]  rc = (i % 50 == 0) ? 8'($urandom) : 8'($urandom % 20);
      logic [15:0] rd = 16'($urandom);
      logic [4:0]  rf = 5'($urandom);
      run(req_of(ro), ro, rw, ru, rc, rd, rf, (i % 7 == 0));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule